// File: doc/BRIEF.md
# Flash Status Polling Register Generator

This block forms the byte a host sees when it polls a flash controller while an embedded program or erase is running. The controller gives it the operation kind, the phase it is in, a bitmap of the blocks under erase, a bitmap of the blocks whose erase failed, and the data bit being written. The read path gives it a read strobe and the block index that the read address falls in. From these it returns an 8-bit status byte, an active-low busy flag and a flag that tells the read path to return normal array data instead of status.

Two toggle bits advance once per read access, on the rising edge of the strobe, and not once per clock. The general toggle bit moves on every access while the operation runs. The block toggle bit moves only for accesses that hit a block being erased. After a failed erase it moves only for accesses that hit a failed block, so the host can find the faulty blocks by reading.

Encodings: `op_kind` 0 = idle, 1 = program, 2 = chip erase, 3 = block erase. `phase` 0 = block-erase append window, 1 = running, 2 = suspended, 3 = failed. A block index at or above the block count hits no block. The suspended phase applies only to the erase kinds.

Top module: `fsp_status_gen`

## Requirements
- R1: After reset with `op_kind` idle, `status` is 8'h00, `busy_n` is 1 and `pass_thru` is 0, and reads while idle change no status bit.
- R2: Status bit 7 is the inverse of `prog_bit7` during a program, and 0 during a chip or block erase in the append, running and failed phases.
- R3: During a suspended erase, status bit 7 is 1 while `rd_blk` names a block set in `erase_map`.
- R4: Status bit 6 inverts once per rising edge of `rd_strb`, at any block index, while an operation is active and not suspended; a strobe held high for many clocks counts as one access.
- R5: Status bit 6 does not change while an erase is suspended, whatever reads occur.
- R6: Status bit 5 becomes 1 when the phase is failed with an operation active and stays 1, also after the operation goes idle, until `err_clr` is pulsed.
- R7: Status bit 3 is 0 during a program and during the block-erase append window, and 1 during a chip erase and a block erase past the append window.
- R8: Outside the failed phase, status bit 2 inverts on each read access to a block set in `erase_map` during an erase, including while suspended, and holds for reads of other blocks and during a program.
- R9: In the failed phase of an erase, status bit 2 inverts only on reads of blocks set in `fail_map` and holds for reads of blocks that erased correctly.
- R10: `busy_n` is 0 while an operation is active and not suspended, and 1 while idle or in erase suspend.
- R11: `pass_thru` is 1 exactly when an erase is suspended and `rd_blk` names a block not set in `erase_map`.
- R12: Status bits 4, 1 and 0 always read 0.
- R13: A pulse on `op_start` returns both toggle bits (6 and 2) to 0, taking priority over a read access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_strb | input | 1 | Host read strobe, level; each rising edge is one access |
| rd_blk | input | BW | Block index of the read address |
| op_kind | input | 2 | Operation kind: 0 idle, 1 program, 2 chip erase, 3 block erase |
| phase | input | 2 | Controller phase: 0 append, 1 running, 2 suspended, 3 failed |
| erase_map | input | NBLK | One bit per block under erase |
| fail_map | input | NBLK | One bit per block whose erase failed |
| prog_bit7 | input | 1 | Bit 7 of the datum being programmed |
| op_start | input | 1 | One-cycle pulse when an operation begins |
| err_clr | input | 1 | One-cycle pulse from the reset command, clears the error bit |
| status | output | 8 | Status byte presented to the host |
| busy_n | output | 1 | Ready/busy flag, 0 = busy |
| pass_thru | output | 1 | Read should return array data, not status |

## Verification
The assertions assume `rd_strb` is a clean level that is low through reset, that `op_start` is pulsed only with the new `op_kind` already applied, and that the suspended phase is only given with an erase kind. They also assume `rd_blk` stays stable while the strobe is high. The bench drives every input on the falling clock edge, and it starts each read with the block index already set. It moves to the suspended phase only during a block erase, and it waits for the internal reset release before the first access.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PROG = 2'd1,
    OP_CHIP = 2'd2,
    OP_BLK  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_APPEND = 2'd0,
    PH_RUN    = 2'd1,
    PH_SUSP   = 2'd2,
    PH_ERR    = 2'd3
  } ph_e;

endpackage

// File: rtl/fsp_rise_det.sv
module fsp_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/fsp_map_pick.sv
module fsp_map_pick #(
  parameter int NBLK = 11,
  parameter int BW   = 4
) (
  input  logic [NBLK-1:0] map,
  input  logic [BW-1:0]   idx,
  output logic            hit
);

  logic [NBLK-1:0] sel;

  for (genvar g = 0; g < NBLK; g++) begin : g_dec
    assign sel[g] = (idx == BW'(g));
  end

  assign hit = |(sel & map);

endmodule

// File: rtl/fsp_tog_cell.sv
module fsp_tog_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic q
);

  logic q_r;
  logic q_d;
  logic en;

  always_comb begin
    en  = clr | adv;
    q_d = clr ? 1'b0 : ~q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= 1'b0;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/fsp_status_gen.sv
module fsp_status_gen #(
  parameter int NBLK = 11,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_strb,
  input  logic [BW-1:0]   rd_blk,
  input  logic [1:0]      op_kind,
  input  logic [1:0]      phase,
  input  logic [NBLK-1:0] erase_map,
  input  logic [NBLK-1:0] fail_map,
  input  logic            prog_bit7,
  input  logic            op_start,
  input  logic            err_clr,
  output logic [7:0]      status,
  output logic            busy_n,
  output logic            pass_thru
);
  import fsp_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_sq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sq <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sq <= rst_s1;
    end
  end

  op_e op;
  ph_e ph;
  assign op = op_e'(op_kind);
  assign ph = ph_e'(phase);

  logic active, is_erase, in_susp;
  assign active   = (op != OP_IDLE);
  assign is_erase = (op == OP_CHIP) || (op == OP_BLK);
  assign in_susp  = is_erase && (ph == PH_SUSP);

  logic rd_rise;
  fsp_rise_det u_rise (
    .clk(clk), .rst_n(rst_sq), .lvl(rd_strb), .rise(rd_rise)
  );

  logic ers_hit, fail_hit;
  fsp_map_pick #(.NBLK(NBLK), .BW(BW)) u_pick_ers (
    .map(erase_map), .idx(rd_blk), .hit(ers_hit)
  );
  fsp_map_pick #(.NBLK(NBLK), .BW(BW)) u_pick_fail (
    .map(fail_map), .idx(rd_blk), .hit(fail_hit)
  );

  // toggle advance conditions
  logic adv_gen, adv_blk, blk_match;
  always_comb begin
    blk_match = (ph == PH_ERR) ? fail_hit : ers_hit;
    adv_gen   = rd_rise && active && !in_susp;
    adv_blk   = rd_rise && is_erase && blk_match;
  end

  logic tog_gen, tog_blk;
  fsp_tog_cell u_tog_gen (
    .clk(clk), .rst_n(rst_sq), .clr(op_start), .adv(adv_gen), .q(tog_gen)
  );
  fsp_tog_cell u_tog_blk (
    .clk(clk), .rst_n(rst_sq), .clr(op_start), .adv(adv_blk), .q(tog_blk)
  );

  // sticky error flag
  logic err_q, err_d, err_en;
  always_comb begin
    err_en = err_clr || (active && (ph == PH_ERR));
    err_d  = !err_clr;
  end

  always_ff @(posedge clk or negedge rst_sq) begin
    if (!rst_sq)     err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  // status byte assembly
  logic poll_bit, timer_bit;
  always_comb begin
    poll_bit  = 1'b0;
    timer_bit = 1'b0;
    case (op)
      OP_PROG: poll_bit  = ~prog_bit7;
      OP_CHIP: begin
        poll_bit  = in_susp && ers_hit;
        timer_bit = 1'b1;
      end
      OP_BLK: begin
        poll_bit  = in_susp && ers_hit;
        timer_bit = (ph != PH_APPEND);
      end
      default: ;
    endcase
  end

  assign status    = {poll_bit, tog_gen, err_q, 1'b0, timer_bit, tog_blk, 2'b00};
  assign busy_n    = !(active && !in_susp);
  assign pass_thru = in_susp && !ers_hit;

endmodule

// File: rtl/fsp_status_chk.sv
module fsp_status_chk #(
  parameter int NBLK = 11,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_strb,
  input logic [BW-1:0]   rd_blk,
  input logic [1:0]      op_kind,
  input logic [1:0]      phase,
  input logic [NBLK-1:0] erase_map,
  input logic            prog_bit7,
  input logic            op_start,
  input logic            err_clr,
  input logic [7:0]      status,
  input logic            busy_n,
  input logic            pass_thru
);

  logic active, erasing_op, susp, ers_sel;
  always_comb begin
    active     = (op_kind != 2'd0);
    erasing_op = (op_kind == 2'd2) || (op_kind == 2'd3);
    susp       = erasing_op && (phase == 2'd2);
    ers_sel    = 1'b0;
    for (int i = 0; i < NBLK; i++)
      if (int'(rd_blk) == i) ers_sel = erase_map[i];
  end

  p_bit7_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 2'd1) |-> (status[7] == !prog_bit7));

  p_bit6_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_strb) && active && !susp && !op_start) |=> (status[6] != $past(status[6])));

  p_bit6_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && !op_start) |=> $stable(status[6]));

  p_err_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !err_clr) |=> status[5]);

  p_bit2_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_strb) && erasing_op && (phase != 2'd3) && !ers_sel && !op_start)
      |=> $stable(status[2]));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !susp) |-> !busy_n);

  p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pass_thru |-> (busy_n && !ers_sel));

  p_start_clr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (status[6] == 1'b0 && status[2] == 1'b0));

endmodule

bind fsp_status_gen fsp_status_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_sq), .rd_strb(rd_strb), .rd_blk(rd_blk),
  .op_kind(op_kind), .phase(phase), .erase_map(erase_map),
  .prog_bit7(prog_bit7), .op_start(op_start), .err_clr(err_clr),
  .status(status), .busy_n(busy_n), .pass_thru(pass_thru)
);

// File: tb/sim_fsp_status_gen.sv
module sim_fsp_status_gen;

  localparam int NBLK = 11;
  localparam int BW   = $clog2(NBLK);

  logic            clk;
  logic            rst_n;
  logic            rd_strb;
  logic [BW-1:0]   rd_blk;
  logic [1:0]      op_kind;
  logic [1:0]      phase;
  logic [NBLK-1:0] erase_map;
  logic [NBLK-1:0] fail_map;
  logic            prog_bit7;
  logic            op_start;
  logic            err_clr;
  logic [7:0]      status;
  logic            busy_n;
  logic            pass_thru;

  fsp_status_gen #(.NBLK(NBLK)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_strb(rd_strb), .rd_blk(rd_blk),
    .op_kind(op_kind), .phase(phase), .erase_map(erase_map),
    .fail_map(fail_map), .prog_bit7(prog_bit7), .op_start(op_start),
    .err_clr(err_clr), .status(status), .busy_n(busy_n), .pass_thru(pass_thru)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  n_chk;
  int  n_err;
  bit  done;
  logic e6, e2;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_op(input logic [1:0] k, input logic [1:0] p);
    op_kind = k;
    phase   = p;
    cyc(1);
  endtask

  task automatic start_op(input logic [1:0] k, input logic [1:0] p);
    op_kind  = k;
    phase    = p;
    op_start = 1'b1;
    cyc(1);
    op_start = 1'b0;
    e6 = 1'b0;
    e2 = 1'b0;
  endtask

  task automatic do_read(input int blk, input int hold);
    rd_blk  = BW'(blk);
    rd_strb = 1'b1;
    cyc(hold);
    rd_strb = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset;
    chk("R1 status", status, 8'h00);
    chk("R1 busy_n", {7'd0, busy_n}, 8'h01);
    chk("R1 pass_thru", {7'd0, pass_thru}, 8'h00);
    do_read(1, 1);
    chk("R1 idle read", status, 8'h00);
  endtask

  task automatic t_program;
    prog_bit7 = 1'b1;
    start_op(2'd1, 2'd1);
    chk("R2 prog bit7", {7'd0, status[7]}, 8'h00);
    chk("R10 busy prog", {7'd0, busy_n}, 8'h00);
    chk("R7 bit3 prog", {7'd0, status[3]}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      do_read(i * 4, 1);
      e6 = ~e6;
      chk("R4 bit6 prog", {7'd0, status[6]}, {7'd0, e6});
      chk("R8 bit2 prog", {7'd0, status[2]}, {7'd0, e2});
    end
    prog_bit7 = 1'b0;
    cyc(1);
    chk("R2 prog bit7 inv", {7'd0, status[7]}, 8'h01);
    chk("R12 reserved", {5'd0, status[4], status[1:0]}, 8'h00);
  endtask

  task automatic t_long_read;
    do_read(3, 20);
    e6 = ~e6;
    chk("R4 long read once", {7'd0, status[6]}, {7'd0, e6});
  endtask

  task automatic t_block_erase;
    erase_map = 11'b000_0000_0110;
    fail_map  = '0;
    // make bit6 nonzero, then start with a read in the same cycle
    if (e6 == 1'b0) begin
      do_read(0, 1);
      e6 = ~e6;
    end
    chk("R4 pre start", {7'd0, status[6]}, 8'h01);
    rd_blk   = BW'(1);
    rd_strb  = 1'b1;
    start_op(2'd3, 2'd0);
    rd_strb  = 1'b0;
    cyc(1);
    chk("R13 start clears", {6'd0, status[6], status[2]}, 8'h00);
    chk("R7 bit3 append", {7'd0, status[3]}, 8'h00);
    chk("R2 erase bit7", {7'd0, status[7]}, 8'h00);
    do_read(1, 1);
    e6 = ~e6; e2 = ~e2;
    chk("R8 bit2 erasing blk", {6'd0, status[6], status[2]}, {6'd0, e6, e2});
    do_read(5, 1);
    e6 = ~e6;
    chk("R8 bit2 other blk", {6'd0, status[6], status[2]}, {6'd0, e6, e2});
    set_op(2'd3, 2'd1);
    chk("R7 bit3 running", {7'd0, status[3]}, 8'h01);
    do_read(2, 1);
    e6 = ~e6; e2 = ~e2;
    chk("R8 bit2 running", {6'd0, status[6], status[2]}, {6'd0, e6, e2});
  endtask

  task automatic t_suspend;
    set_op(2'd3, 2'd2);
    chk("R10 busy susp", {7'd0, busy_n}, 8'h01);
    do_read(1, 1);
    e2 = ~e2;
    chk("R3 bit7 susp", {7'd0, status[7]}, 8'h01);
    chk("R8 bit2 susp", {7'd0, status[2]}, {7'd0, e2});
    chk("R5 bit6 frozen", {7'd0, status[6]}, {7'd0, e6});
    chk("R11 no pass erasing", {7'd0, pass_thru}, 8'h00);
    do_read(7, 2);
    chk("R11 pass other", {7'd0, pass_thru}, 8'h01);
    chk("R5 bit6 frozen 2", {6'd0, status[6], status[2]}, {6'd0, e6, e2});
    set_op(2'd3, 2'd1);
    chk("R11 pass resumed", {7'd0, pass_thru}, 8'h00);
    chk("R10 busy resumed", {7'd0, busy_n}, 8'h00);
  endtask

  task automatic t_error;
    fail_map = 11'b000_0000_0100;
    set_op(2'd3, 2'd3);
    chk("R6 err set", {7'd0, status[5]}, 8'h01);
    chk("R2 bit7 err", {7'd0, status[7]}, 8'h00);
    do_read(1, 1);
    e6 = ~e6;
    chk("R9 good blk hold", {6'd0, status[6], status[2]}, {6'd0, e6, e2});
    do_read(2, 1);
    e6 = ~e6; e2 = ~e2;
    chk("R9 failed blk toggles", {6'd0, status[6], status[2]}, {6'd0, e6, e2});
    set_op(2'd0, 2'd1);
    cyc(3);
    chk("R6 err sticky", {7'd0, status[5]}, 8'h01);
    chk("R10 idle ready", {7'd0, busy_n}, 8'h01);
    err_clr = 1'b1;
    cyc(1);
    err_clr = 1'b0;
    cyc(1);
    chk("R6 err cleared", {7'd0, status[5]}, 8'h00);
  endtask

  task automatic t_chip;
    erase_map = '1;
    fail_map  = '0;
    start_op(2'd2, 2'd1);
    chk("R7 chip bit3", status, 8'h08);
    do_read(10, 1);
    e6 = ~e6; e2 = ~e2;
    chk("R8 chip toggles", {6'd0, status[6], status[2]}, {6'd0, e6, e2});
    do_read(12, 1);
    e6 = ~e6;
    chk("R8 out of range blk", {6'd0, status[6], status[2]}, {6'd0, e6, e2});
    chk("R12 reserved chip", {5'd0, status[4], status[1:0]}, 8'h00);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    e6 = 1'b0; e2 = 1'b0;
    rst_n = 1'b0; rd_strb = 1'b0; rd_blk = '0;
    op_kind = 2'd0; phase = 2'd1; erase_map = '0; fail_map = '0;
    prog_bit7 = 1'b0; op_start = 1'b0; err_clr = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_program();
    t_long_read();
    t_block_erase();
    t_suspend();
    t_error();
    t_chip();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule